// File: doc/BRIEF.md
# Device Directory Table Walker

This block turns a device identifier into the memory address of that device's context record. The records sit in a radix tree in memory, and the tree has one, two or three levels. A requester supplies three things: the identifier, the page number of the root table and the tree depth. It also supplies a flag that selects one of two context formats. The compact format uses 32-byte records. The wide format uses 64-byte records. The format changes how the identifier is cut into per-level index fields.

The walker starts at the root page and works down toward the leaf page. At each non-leaf level it fetches one 64-bit entry through a read port with its own request/response handshake. The memory latency can vary. The walker checks the entry's valid flag and takes the next page number from the entry. At the leaf page it adds the leaf index times the record size and returns the result. A walk ends early with a fault code in three cases: the depth code is illegal, the identifier is wider than the chosen depth can index, or a fetched entry is marked invalid. Only one walk is in flight at a time.

Top module: `ddt_walker`

## Requirements
- R1: After reset, and after a reset that lands in the middle of a walk, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are both 0.
- R2: Out-of-range identifiers fault with code 1 (range) and make no memory read. The limit is 2^7, 2^16 or 2^24 for depths 1, 2 and 3 in compact format, and 2^6, 2^15 or 2^24 in wide format.
- R3: Compact format (`req_ext`=0), depth 1: the result is root + id[6:0]·32, where root = `req_root_ppn`·4096. No memory read is made.
- R4: Wide format (`req_ext`=1): the leaf index is id[5:0], times 64. The middle index is id[14:6]. The top index is id[23:15].
- R5: For depth d (`req_mode`=d, 1..3) the walker makes exactly d−1 reads, top level first. For each non-leaf level the entry address is page + index·8. In compact format the top index is id[23:16] and the middle index is id[15:7].
- R6: An entry with bit 0 clear ends the walk with fault code 2 (invalid). No further read follows.
- R7: The next page address is entry bits 53:10 placed at address bits 55:12. Entry bits 63:54 and 9:1 have no effect.
- R8: `req_mode`=0 faults with code 3 (mode) and makes no memory read. This check takes priority over the range check.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays unchanged, and no new request is accepted until the response is taken.
- R11: The walker has at most one read outstanding and waits any number of cycles for `mem_rsp_valid`.
- R12: A successful walk returns fault code 0. A faulted walk returns `rsp_addr` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_devid | input | 24 | Device identifier |
| req_root_ppn | input | 44 | Root table page number |
| req_mode | input | 2 | Tree depth: 0 illegal, 1..3 levels |
| req_ext | input | 1 | 1 = wide 64-byte context format |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken |
| rsp_addr | output | 56 | Context address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 range, 2 invalid entry, 3 mode |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | 56 | Byte address of entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry contents |

## Verification
The hardest case to reach is an invalid entry one level below a valid one. The walker must follow a good top entry and then stop on the middle entry without issuing a third read. The stimulus reaches it by filling the memory model with one real top-level entry and a poisoned neighbour at the middle level. The identifier's middle index then steers the walk onto the poisoned slot. The memory model stalls its ready and varies its latency from read to read, so every walk crosses the R9 hold window and the R11 wait window. A reset is also asserted while a walk is mid-flight, to confirm the walker recovers.

// File: rtl/ddw_pkg.sv
package ddw_pkg;
    localparam int DID_W    = 24;
    localparam int DW       = 64;
    localparam int PPN_W    = 44;
    localparam int PG_SH    = 12;
    localparam int PA_W     = PPN_W + PG_SH;
    localparam int PPN_LSB  = 10;
    localparam int NL_W     = 9;
    localparam int LEAF_W_B = 7;
    localparam int LEAF_W_E = 6;
    localparam int ENT_SH   = 3;
    localparam int CTX_SH_B = 5;
    localparam int CTX_SH_E = 6;
    localparam int LVL_W    = 2;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_RANGE   = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_MODE    = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_RDREQ,
        ST_RDWAIT,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic [NL_W-1:0]     top;
        logic [NL_W-1:0]     mid;
        logic [LEAF_W_B-1:0] leaf;
    } did_idx_t;

    // number of identifier bits a tree of the given depth can index
    function automatic logic [4:0] span_bits(input logic ext, input logic [LVL_W-1:0] depth);
        logic [4:0] lw;
        lw = ext ? 5'(LEAF_W_E) : 5'(LEAF_W_B);
        case (depth)
            2'd0:    return lw;
            2'd1:    return lw + 5'(NL_W);
            default: return 5'(DID_W);
        endcase
    endfunction
endpackage

// File: rtl/ddw_index_split.sv
module ddw_index_split
    import ddw_pkg::*;
(
    input  logic [DID_W-1:0] devid,
    input  logic             ext,
    input  logic [1:0]       mode,
    output did_idx_t         idx,
    output logic [LVL_W-1:0] depth,
    output logic             mode_ok,
    output logic             range_ok
);
    localparam int MID_LO_B = LEAF_W_B;
    localparam int MID_LO_E = LEAF_W_E;
    localparam int TOP_LO_B = LEAF_W_B + NL_W;
    localparam int TOP_LO_E = LEAF_W_E + NL_W;

    logic [4:0] span;

    always_comb begin
        if (ext) begin
            idx.leaf = LEAF_W_B'(devid[LEAF_W_E-1:0]);
            idx.mid  = devid[MID_LO_E +: NL_W];
            idx.top  = NL_W'(devid[DID_W-1:TOP_LO_E]);
        end else begin
            idx.leaf = devid[LEAF_W_B-1:0];
            idx.mid  = devid[MID_LO_B +: NL_W];
            idx.top  = NL_W'(devid[DID_W-1:TOP_LO_B]);
        end
    end

    assign mode_ok  = (mode != 2'd0);
    assign depth    = LVL_W'(mode - 2'd1);
    assign span     = span_bits(ext, depth);
    assign range_ok = ((devid >> span) == '0);
endmodule

// File: rtl/ddw_addr_gen.sv
module ddw_addr_gen
    import ddw_pkg::*;
(
    input  logic [PA_W-1:0]  base,
    input  did_idx_t         idx,
    input  logic             ext,
    input  logic [LVL_W-1:0] lvl,
    output logic [PA_W-1:0]  entry_addr,
    output logic [PA_W-1:0]  leaf_addr
);
    logic [NL_W-1:0] sel;

    assign sel        = (lvl == 2'd2) ? idx.top : idx.mid;
    assign entry_addr = base + (PA_W'(sel) << ENT_SH);
    assign leaf_addr  = base + (ext ? (PA_W'(idx.leaf) << CTX_SH_E)
                                    : (PA_W'(idx.leaf) << CTX_SH_B));
endmodule

// File: rtl/ddt_walker.sv
module ddt_walker
    import ddw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [DID_W-1:0] req_devid,
    input  logic [PPN_W-1:0] req_root_ppn,
    input  logic [1:0]       req_mode,
    input  logic             req_ext,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_addr,
    output logic [1:0]       rsp_fault,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [DW-1:0]    mem_rsp_data
);
    state_e           state;
    did_idx_t         idx_q;
    logic             ext_q;
    logic [LVL_W-1:0] lvl_q;
    logic [PA_W-1:0]  base_q;
    logic [PA_W-1:0]  addr_q;
    fault_e           fault_q;

    did_idx_t         sp_idx;
    logic [LVL_W-1:0] sp_depth;
    logic             sp_mode_ok;
    logic             sp_range_ok;
    logic [PA_W-1:0]  entry_addr;
    logic [PA_W-1:0]  leaf_addr;
    logic [PA_W-1:0]  nxt_page;
    logic             data_unused;

    ddw_index_split split_i (
        .devid    (req_devid),
        .ext      (req_ext),
        .mode     (req_mode),
        .idx      (sp_idx),
        .depth    (sp_depth),
        .mode_ok  (sp_mode_ok),
        .range_ok (sp_range_ok)
    );

    ddw_addr_gen agen_i (
        .base       (base_q),
        .idx        (idx_q),
        .ext        (ext_q),
        .lvl        (lvl_q),
        .entry_addr (entry_addr),
        .leaf_addr  (leaf_addr)
    );

    assign nxt_page    = {mem_rsp_data[PPN_LSB +: PPN_W], {PG_SH{1'b0}}};
    assign data_unused = ^{mem_rsp_data[DW-1:PPN_LSB+PPN_W], mem_rsp_data[PPN_LSB-1:1]};

    assign req_ready     = (state == ST_IDLE);
    assign rsp_valid     = (state == ST_RESP);
    assign rsp_addr      = addr_q;
    assign rsp_fault     = fault_q;
    assign mem_req_valid = (state == ST_RDREQ);
    assign mem_req_addr  = entry_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx_q   <= '0;
            ext_q   <= 1'b0;
            lvl_q   <= '0;
            base_q  <= '0;
            addr_q  <= '0;
            fault_q <= FLT_NONE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        idx_q  <= sp_idx;
                        ext_q  <= req_ext;
                        lvl_q  <= sp_depth;
                        base_q <= {req_root_ppn, {PG_SH{1'b0}}};
                        addr_q <= '0;
                        if (!sp_mode_ok) begin
                            fault_q <= FLT_MODE;
                            state   <= ST_RESP;
                        end else if (!sp_range_ok) begin
                            fault_q <= FLT_RANGE;
                            state   <= ST_RESP;
                        end else begin
                            fault_q <= FLT_NONE;
                            state   <= ST_STEP;
                        end
                    end
                end
                ST_STEP: begin
                    if (lvl_q == '0) begin
                        addr_q <= leaf_addr;
                        state  <= ST_RESP;
                    end else begin
                        state <= ST_RDREQ;
                    end
                end
                ST_RDREQ: begin
                    if (mem_req_ready) state <= ST_RDWAIT;
                end
                ST_RDWAIT: begin
                    if (mem_rsp_valid) begin
                        if (!mem_rsp_data[0]) begin
                            fault_q <= FLT_INVALID;
                            state   <= ST_RESP;
                        end else begin
                            base_q <= nxt_page;
                            lvl_q  <= LVL_W'(lvl_q - 2'd1);
                            state  <= ST_STEP;
                        end
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ddw_checker.sv
module ddw_checker
    import ddw_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_addr,
    input logic [1:0]      rsp_fault,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid
);
    logic       seen_rd;
    logic [1:0] outst;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_rd <= 1'b0;
            outst   <= '0;
        end else begin
            if (req_valid && req_ready) seen_rd <= 1'b0;
            else if (mem_req_valid && mem_req_ready) seen_rd <= 1'b1;
            if (mem_req_valid && mem_req_ready) outst <= outst + 2'd1;
            else if (mem_rsp_valid && outst != '0) outst <= outst - 2'd1;
        end
    end

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !mem_req_valid));

    // R9
    memreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));

    // R10
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && rsp_valid));

    // R11
    one_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (outst == 2'd0));

    // R2 R8
    noread_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_fault == FLT_RANGE || rsp_fault == FLT_MODE)) |-> !seen_rd);

    // R6
    inv_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == FLT_INVALID) |-> seen_rd);

    // R12
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_addr == '0));
endmodule

bind ddt_walker ddw_checker chk_i (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_addr      (rsp_addr),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/ddt_walker_tb_top.sv
`timescale 1ns/1ps
module ddt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [23:0] req_devid;
    logic [43:0] req_root_ppn;
    logic [1:0]  req_mode;
    logic        req_ext;
    logic        rsp_valid, rsp_ready;
    logic [55:0] rsp_addr;
    logic [1:0]  rsp_fault;
    logic        mem_req_valid, mem_req_ready;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;

    always #2.5 clk = ~clk;

    ddt_walker dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_devid(req_devid),
        .req_root_ppn(req_root_ppn), .req_mode(req_mode), .req_ext(req_ext),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    typedef struct packed {
        logic [23:0] did;
        logic [1:0]  mode;
        logic        ext;
        logic [1:0]  flt;
        logic [1:0]  nrd;
        logic [55:0] addr;
        logic [55:0] rd0;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{24'h123456, 2'd3, 1'b0, 2'd0, 2'd2, 56'h300AC0, 56'h100090},
        '{24'h123456, 2'd3, 1'b1, 2'd0, 2'd2, 56'h500580, 56'h100120},
        '{24'h00ABCD, 2'd2, 1'b0, 2'd0, 2'd1, 56'h6009A0, 56'h100AB8},
        '{24'h010000, 2'd2, 1'b0, 2'd1, 2'd0, 56'h0,      56'h0},
        '{24'h008000, 2'd2, 1'b1, 2'd1, 2'd0, 56'h0,      56'h0},
        '{24'h007FFF, 2'd2, 1'b1, 2'd0, 2'd1, 56'h700FC0, 56'h100FF8},
        '{24'h00007F, 2'd1, 1'b0, 2'd0, 2'd0, 56'h100FE0, 56'h0},
        '{24'h000080, 2'd1, 1'b0, 2'd1, 2'd0, 56'h0,      56'h0},
        '{24'h00003F, 2'd1, 1'b1, 2'd0, 2'd0, 56'h100FC0, 56'h0},
        '{24'h000040, 2'd1, 1'b1, 2'd1, 2'd0, 56'h0,      56'h0},
        '{24'h050000, 2'd3, 1'b0, 2'd2, 2'd1, 56'h0,      56'h100028},
        '{24'h120080, 2'd3, 1'b0, 2'd2, 2'd2, 56'h0,      56'h100090},
        '{24'h000000, 2'd0, 1'b0, 2'd3, 2'd0, 56'h0,      56'h0},
        '{24'h000000, 2'd1, 1'b0, 2'd0, 2'd0, 56'h100000, 56'h0}
    };

    logic [63:0] mem [logic [55:0]];
    int n_chk = 0, n_bad = 0;
    int nrd, rsp_cnt = 0;
    logic [55:0] rd0;
    bit done = 0;

    function automatic logic [63:0] mem_rd(input logic [55:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: stalls ready and varies return latency
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [55:0] a;
                repeat (rsp_cnt % 3) @(negedge clk);
                a = mem_req_addr;
                mem_req_ready = 1'b1;
                if (nrd == 0) rd0 = a;
                nrd++;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (rsp_cnt % 4) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_rd(a);
                rsp_cnt++;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic run_vec(input vec_t v, input int hold);
        string tg;
        logic [55:0] a0;
        logic [1:0]  f0;
        if (v.mode == 2'd0)      tg = "R8";
        else if (v.flt == 2'd1)  tg = "R2";
        else if (v.flt == 2'd2)  tg = "R6";
        else if (v.mode == 2'd1) tg = v.ext ? "R4" : "R3";
        else                     tg = v.ext ? "R4 R5" : "R5 R7";
        nrd = 0;
        rd0 = '0;
        @(negedge clk);
        req_devid = v.did; req_mode = v.mode; req_ext = v.ext;
        req_root_ppn = 44'h100; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        a0 = rsp_addr; f0 = rsp_fault;
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            chk(rsp_valid && rsp_addr == a0 && rsp_fault == f0, "R10", "held response",
                {8'h0, rsp_addr}, {8'h0, a0});
            chk(!req_ready, "R10", "req_ready while response pending", 64'(req_ready), 64'h0);
        end
        chk(rsp_fault == v.flt, tg, "fault code", 64'(rsp_fault), 64'(v.flt));
        chk(rsp_addr == v.addr, (v.flt != 0) ? "R12" : tg, "context address",
            {8'h0, rsp_addr}, {8'h0, v.addr});
        chk(nrd == int'(v.nrd), "R5 R9 R11", "read count", 64'(nrd), 64'(v.nrd));
        if (v.nrd != 0)
            chk(rd0 == v.rd0, "R5", "first read address", {8'h0, rd0}, {8'h0, v.rd0});
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    initial begin
        mem[56'h100090] = 64'hFFC0_0000_0008_03FF; // junk in 63:54 and 9:1 (R7)
        mem[56'h200340] = 64'h0000_0000_000C_0001;
        mem[56'h100120] = 64'h0000_0000_0010_0001;
        mem[56'h400688] = 64'h0000_0000_0014_0001;
        mem[56'h100AB8] = 64'h0000_0000_0018_0001;
        mem[56'h100FF8] = 64'h0000_0000_001C_0001;
        mem[56'h200008] = 64'h0000_0000_000F_FFFE; // valid bit clear
        rst = 1'b1; req_valid = 1'b0; rsp_ready = 1'b0;
        req_devid = '0; req_root_ppn = '0; req_mode = '0; req_ext = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'h1);
        chk(!rsp_valid, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'h0);
        chk(!mem_req_valid, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'h0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], (i % 4 == 1) ? 3 : 0);

        // R1 reset in the middle of a three-level walk
        @(negedge clk);
        req_devid = 24'h123456; req_mode = 2'd3; req_ext = 1'b0;
        req_root_ppn = 44'h100; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid, "R1", "idle after mid-walk reset",
            {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
        repeat (20) @(negedge clk);
        run_vec(VECS[1], 2);
        run_vec(VECS[11], 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule